// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which of eight DMA channels the transfer engine serves next. Each channel raises a request bit. The arbiter answers with a one-hot grant and keeps that grant fixed for the whole transfer. The transfer engine reports progress on a per-channel acknowledge vector. The grant is released only after the acknowledge of the granted channel has gone high and then low again. No other channel can win while a grant is held.

A single mode input picks one of two orderings. In fixed ordering, lower channel numbers always win. In rotating ordering, the channel served most recently falls to the bottom and the rest follow it in circular order. The mode is read only at the moment a new grant is decided. Address generation, counting and bus timing belong to other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set at any time, and bit i stands for channel i (i = 0..7).
- R2: When no grant is held, the pending requests are sampled at a rising clock edge and the winner's grant bit is set at that same edge, so the grant is visible one cycle after the request. If no request is pending, `gnt_o` stays all-zero.
- R3: With `mode_i` = 0 (fixed ordering), the pending request with the lowest channel number wins.
- R4: With `mode_i` = 1 (rotating ordering), the search starts at the channel after the last-served channel and wraps from 7 to 0, so the last-served channel comes last.
- R5: While a grant is held, it does not change, whatever happens on the requests, the mode, or the acknowledges of other channels. This holds until the granted channel's acknowledge has been sampled high and then sampled low.
- R6: At the clock edge that samples the granted channel's acknowledge low after it was sampled high, `gnt_o` clears to zero for one cycle. The next arbitration then uses the requests present in that cycle.
- R7: The last-served channel is updated to the completing channel only at completion, in either mode. It does not change at any other time.
- R8: A change of `mode_i` while a grant is held has no effect on that grant. It only affects the next arbitration.
- R9: Reset (`rst_ni` low) clears `gnt_o` and sets the last-served channel to 7, so channel 0 starts highest in rotating ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Per-channel service request |
| mode_i | input | 1 | 0 = fixed ordering, 1 = rotating ordering |
| ack_i | input | 8 | Per-channel acknowledge (transfer busy) from the transfer engine |
| gnt_o | output | 8 | One-hot grant, all-zero when idle |

## Verification
A new grant is due one clock after the request is seen by an idle arbiter. Completion clears the grant at the edge that samples the acknowledge low, and the next grant follows one edge later, so there is always a one-cycle gap. The bench's reference model steps on each rising edge using the inputs driven at the previous falling edge. The grant is compared at every falling edge, which is half a cycle after the edge that set it. The directed checks use the same timing, so each expected value is read in exactly the cycle in which it is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_XFER     = 2'd2
  } lock_st_e;

endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NCH   = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);

  // Scan from the top down so that the lowest set channel is the final assignment.
  always_comb begin
    idx_o   = '0;
    valid_o = |req_i;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R3: no pending request below the chosen one
  always_comb begin
    if (valid_o) begin
      a_r3_lowest_wins: assert ((req_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0);
    end
  end

endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
  parameter int NCH   = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);

  logic [IDX_W-1:0] cand;

  // Distance k = 1 is the highest priority and k = NCH (the last-served channel) the lowest.
  // Scan from far to near so that the nearest requester is the final assignment.
  always_comb begin
    idx_o   = last_i;
    valid_o = |req_i;
    cand    = '0;
    for (int k = NCH; k >= 1; k--) begin
      cand = IDX_W'((int'(last_i) + k) % NCH);
      if (req_i[cand]) idx_o = cand;
    end
  end

  // R4: the chosen channel is really requesting
  always_comb begin
    if (valid_o) begin
      a_r4_pick_requested: assert (req_i[idx_o]);
    end
  end

endmodule

// File: rtl/arb_lock_ctrl.sv
module arb_lock_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  arb_mode_e        mode_i,
  input  logic [IDX_W-1:0] fix_idx_i,
  input  logic             fix_vld_i,
  input  logic [IDX_W-1:0] rot_idx_i,
  input  logic             rot_vld_i,
  input  logic [NCH-1:0]   ack_i,
  output logic [NCH-1:0]   gnt_o,
  output logic [IDX_W-1:0] last_o,
  output logic             arb_ev_o,
  output logic             done_ev_o
);

  lock_st_e         st_q;
  logic [IDX_W-1:0] own_q;
  logic [IDX_W-1:0] last_q;
  logic [NCH-1:0]   gnt_q;
  logic             own_ack;
  logic [IDX_W-1:0] win_idx;
  logic             win_vld;

  // Named internal events, used by the sequential logic and by the assertions.
  assign own_ack   = ack_i[own_q];
  assign win_idx   = (mode_i == ARB_ROUND) ? rot_idx_i : fix_idx_i;
  assign win_vld   = (mode_i == ARB_ROUND) ? rot_vld_i : fix_vld_i;
  assign arb_ev_o  = (st_q == ST_IDLE) && win_vld;
  assign done_ev_o = (st_q == ST_XFER) && !own_ack;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      own_q  <= '0;
      last_q <= IDX_W'(NCH - 1);
      gnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (arb_ev_o) begin
            own_q <= win_idx;
            gnt_q <= NCH'(1) << win_idx;
            st_q  <= ST_WAIT_ACK;
          end
        end
        ST_WAIT_ACK: begin
          if (own_ack) st_q <= ST_XFER;
        end
        ST_XFER: begin
          if (done_ev_o) begin
            st_q   <= ST_IDLE;
            gnt_q  <= '0;
            last_q <= own_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_o  = gnt_q;
  assign last_o = last_q;

  // R1: grant is one-hot or zero
  a_r1_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R5: a held grant only changes at completion
  a_r5_grant_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !done_ev_o) |=> (gnt_o == $past(gnt_o)));

  // R6: completion leaves a zero grant for the following cycle
  a_r6_gap_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ev_o |=> (gnt_o == '0));

  // R7: the last-served pointer moves only at completion
  a_r7_ptr_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_ev_o |=> $stable(last_o));

  // R2: a fresh grant goes to a channel that was requesting
  a_r2_grant_was_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gnt_o) == '0 && gnt_o != '0) |-> (($past(req_i) & gnt_o) != '0));

  // R2: idle with no request keeps the grant at zero
  a_r2_idle_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i == '0) |=> (gnt_o == '0));

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           mode_i,
  input  logic [NCH-1:0] ack_i,
  output logic [NCH-1:0] gnt_o
);

  logic [IDX_W-1:0] fix_idx;
  logic             fix_vld;
  logic [IDX_W-1:0] rot_idx;
  logic             rot_vld;
  logic [IDX_W-1:0] last_srv;
  logic             arb_ev;
  logic             done_ev;
  arb_mode_e        mode;

  assign mode = arb_mode_e'(mode_i);

  arb_fixed_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_fixed (
    .req_i   (req_i),
    .idx_o   (fix_idx),
    .valid_o (fix_vld)
  );

  arb_rot_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_rot (
    .req_i   (req_i),
    .last_i  (last_srv),
    .idx_o   (rot_idx),
    .valid_o (rot_vld)
  );

  arb_lock_ctrl #(.NCH(NCH), .IDX_W(IDX_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .mode_i    (mode),
    .fix_idx_i (fix_idx),
    .fix_vld_i (fix_vld),
    .rot_idx_i (rot_idx),
    .rot_vld_i (rot_vld),
    .ack_i     (ack_i),
    .gnt_o     (gnt_o),
    .last_o    (last_srv),
    .arb_ev_o  (arb_ev),
    .done_ev_o (done_ev)
  );

  // R8: a mode change never alters a grant that is being held
  a_r8_mode_no_effect_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !done_ev && mode_i != $past(mode_i)) |=> (gnt_o == $past(gnt_o)));

  // R2: every arbitration event yields a grant at the next edge
  a_r2_arb_gives_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_ev |=> (gnt_o != '0));

endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic       mode;
  logic [7:0] ack;
  logic [7:0] gnt;

  always #5 clk = ~clk;

  dma_prio_arbiter i_dma_prio_arbiter (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .mode_i (mode),
    .ack_i  (ack),
    .gnt_o  (gnt)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  bit model_on = 0;

  // Reference model: owner (-1 = none), ack-seen flag, last served channel.
  int m_own  = -1;
  bit m_seen = 0;
  int m_last = 7;

  function automatic int model_pick(logic [7:0] r, logic m, int lst);
    if (!m) begin
      for (int i = 0; i < 8; i++) if (r[i]) return i;
    end else begin
      for (int k = 1; k <= 8; k++) if (r[(lst + k) % 8]) return (lst + k) % 8;
    end
    return -1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_seen = 0; m_last = 7;
    end else if (m_own < 0) begin
      m_own  = model_pick(req, mode, m_last);
      m_seen = 0;
    end else if (m_seen && !ack[m_own]) begin
      m_last = m_own;
      m_own  = -1;
    end else if (ack[m_own]) begin
      m_seen = 1;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R2/R3/R4/R5/R6/R7 model", gnt, (m_own < 0) ? 8'h00 : (8'h01 << m_own));
      total++;
      if ($countones(gnt) > 1) begin
        bad++;
        $display("FAIL R1 onehot actual=%h expected=at most one bit", gnt);
      end
    end
  end

  task automatic run_xfer(int hi);
    int g;
    g = -1;
    for (int i = 0; i < 8; i++) if (gnt[i]) g = i;
    if (g < 0) begin
      check("R5 grant expected before transfer", gnt, 8'hFF);
      return;
    end
    ack[g] = 1'b1;
    repeat (hi) @(negedge clk);
    ack[g] = 1'b0;
    @(negedge clk);
    check("R6 gap after completion", gnt, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; mode = 1'b0; ack = '0;
    repeat (3) @(negedge clk);
    check("R9 reset grant", gnt, 8'h00);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);
    check("R2 idle no request", gnt, 8'h00);

    // R9/R4: rotating from reset, channel 0 first
    mode = 1'b1; req = 8'h81;
    @(negedge clk);
    check("R4 R9 reset pointer gives ch0", gnt, 8'h01);
    run_xfer(2);
    @(negedge clk);
    check("R4 after ch0 ch7 wins", gnt, 8'h80);

    // R8/R5 while ch7 held
    mode = 1'b0; req = 8'hF0; ack[2] = 1'b1;
    @(negedge clk);
    check("R8 mode change during hold", gnt, 8'h80);
    ack[2] = 1'b0;
    @(negedge clk);
    check("R5 other ack ignored", gnt, 8'h80);
    repeat (3) @(negedge clk);
    check("R5 hold without ack", gnt, 8'h80);
    run_xfer(1);
    @(negedge clk);
    check("R3 fixed lowest of F0", gnt, 8'h10);
    req = 8'hF1;
    @(negedge clk);
    check("R5 lower request during hold", gnt, 8'h10);
    run_xfer(3);
    @(negedge clk);
    check("R3 fixed ch0 wins", gnt, 8'h01);

    // R8: mode change takes effect at next arbitration
    mode = 1'b1; req = 8'h13;
    @(negedge clk);
    check("R8 hold after mode change", gnt, 8'h01);
    run_xfer(1);
    @(negedge clk);
    check("R8 rotating after ch0 gives ch1", gnt, 8'h02);
    run_xfer(2);
    @(negedge clk);
    check("R7 pointer at ch1 gives ch4", gnt, 8'h10);

    // R2: no request after completion
    req = 8'h00;
    run_xfer(1);
    @(negedge clk);
    check("R2 no request stays zero", gnt, 8'h00);
    req = 8'h40;
    @(negedge clk);
    check("R2 one-cycle latency", gnt, 8'h40);
    run_xfer(1);

    // Random phase: the model compares on every cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      req = 8'($urandom);
      if (($urandom % 16) == 0) mode = ~mode;
      ack = 8'($urandom) & 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        if (gnt[i]) ack[i] = (($urandom % 3) != 0);
      end
    end
    @(negedge clk);
    ack = '0; req = '0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule